// File: doc/BRIEF.md
# SPI Register Slave with Power-State Host Commands

This block is an SPI mode 0 slave that gives a host byte access to a small register space and also takes three-byte host commands that steer the device's power and clock configuration. Every chip-select-low window is one transaction. The two top bits of the first byte choose the transaction kind. The rest of the first three bytes form a 22-bit byte address, or for a host command they carry the command code, a parameter and a zero byte.

After reset the device is asleep. While it sleeps, reads return zero and writes are dropped. The host may pick the clock source and the clock rate only in this state. A three-byte all-zero transaction wakes the device. An internal CPU-reset interval then runs, and software polls the identification and CPU-reset status registers until the device reports ready. SPI pins are oversampled in the system clock domain. The SPI clock must therefore be well below the system clock.

Top module: `spi_regmap_slave`

## Requirements
- R1: A transaction begins when cs_ni falls and ends when it rises. Bits of an incomplete trailing byte have no effect.
- R2: The top two bits of the first byte set the kind. 00 is a read, 10 is a write, 01 is a host command and 11 is ignored. The low six bits of byte 0, then byte 1, then byte 2 form the 22-bit address, most significant first.
- R3: A read sends one dummy byte (MISO low) after the three address bytes. It then returns one data byte for each further byte clocked, MSB first. MISO changes after SCK falls and is valid at the next rise. The address increments by one per byte, and MISO is low outside a transaction.
- R4: A write stores each byte that follows the three address bytes at an address that increments by one per byte. A 32-bit value sent least significant byte first therefore lands little-endian.
- R5: Address 0x000000 reads 0x7C (identification) and 0x000001 reads the CPU-reset status. Addresses BASE to BASE+DEPTH-1 (default 0x10 to 0x1F) are read/write scratch bytes. All other addresses read 0x00, and writes to them or to the two status registers are ignored.
- R6: While asleep, every read returns 0x00 and every write is ignored.
- R7: A transaction of exactly three full bytes 0x00 0x00 0x00 moves the device from sleep to active (active_o high). Active is never left except by rst_ni, and a repeated wake has no effect.
- R8: A host command is executed at the end of its transaction only if exactly three full bytes were sent and the third byte is 0x00.
- R9: Command 0x44 sets ext_clk_o, and command 0x61 loads its parameter byte into clk_rate_o. Both take effect only while asleep and are ignored once active.
- R10: On wake, the CPU-reset status register reads 0x01 for RST_CYCLES system clocks and then reads 0x00. Command 0x68 while active restarts this interval.
- R11: After reset, miso_o, active_o and ext_clk_o are low and clk_rate_o equals CLK_RATE_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also used to oversample the SPI pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI clock, mode 0 |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from the host |
| miso_o | output | 1 | SPI data to the host |
| active_o | output | 1 | Device is awake |
| ext_clk_o | output | 1 | External clock source selected |
| clk_rate_o | output | 8 | Selected system clock rate code |

## Verification
A wrong transaction kind or byte count shows up at the very next frame end. The symptom is a wake or clock command taking effect when it should not, or failing to, and it appears within a few system clocks of cs_ni rising. A wrong address counter or a misplaced MISO load corrupts the first data byte after the dummy byte of a read. A stuck power state or reset counter is caught the first time the status or identification register is polled after the wake. Scratch writes are always read back in a separate transaction, so a dropped or misdirected write is seen at MISO in that later read.

// File: rtl/spi_regmap_pkg.sv
package spi_regmap_pkg;
  localparam int ADDR_W = 22;

  typedef enum logic [1:0] {
    KIND_RD = 2'b00,
    KIND_HC = 2'b01,
    KIND_WR = 2'b10,
    KIND_XX = 2'b11
  } xfer_kind_e;

  typedef enum logic {
    PWR_SLEEP  = 1'b0,
    PWR_ACTIVE = 1'b1
  } pwr_state_e;

  localparam logic [7:0] ID_CODE     = 8'h7C;
  localparam logic [7:0] HC_EXT_CLK  = 8'h44;
  localparam logic [7:0] HC_CLK_RATE = 8'h61;
  localparam logic [7:0] HC_CORE_RST = 8'h68;

  localparam logic [ADDR_W-1:0] ADDR_ID     = 22'h000000;
  localparam logic [ADDR_W-1:0] ADDR_CPURST = 22'h000001;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int           N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [1:0] stg;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg <= {2{RST_VAL[g]}};
      else         stg <= {stg[0], async_i[g]};
    end
    assign sync_o[g] = stg[1];
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       sel_i,
  input  logic       sck_i,
  input  logic       mosi_i,
  input  logic       load_i,
  input  logic [7:0] load_byte_i,
  output logic       load_slot_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o,
  output logic       miso_o
);
  logic       sck_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic       sck_rise, sck_fall;

  assign sck_rise = sck_i & ~sck_q;
  assign sck_fall = ~sck_i & sck_q;
  // first falling edge after a full byte: next MISO byte goes out here
  assign load_slot_o = sel_i & sck_fall & (bit_cnt == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q       <= 1'b0;
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      byte_done_o <= 1'b0;
      rx_byte_o   <= '0;
    end else begin
      sck_q       <= sck_i;
      byte_done_o <= 1'b0;
      if (start_i) begin
        bit_cnt <= '0;
        tx_sh   <= '0;
      end else if (sel_i) begin
        if (sck_rise) begin
          rx_sh   <= {rx_sh[5:0], mosi_i};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_done_o <= 1'b1;
            rx_byte_o   <= {rx_sh, mosi_i};
          end
        end
        if (sck_fall) tx_sh <= load_i ? load_byte_i : {tx_sh[6:0], 1'b0};
      end
    end
  end

  assign miso_o = sel_i & tx_sh[7];
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl import spi_regmap_pkg::*; #(
  parameter int         RST_CYCLES   = 2000,
  parameter logic [7:0] CLK_RATE_RST = 8'd60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wake_i,
  input  logic       cmd_i,
  input  logic [7:0] code_i,
  input  logic [7:0] param_i,
  output logic       active_o,
  output logic       ext_clk_o,
  output logic [7:0] clk_rate_o,
  output logic       busy_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  pwr_state_e       pwr;
  logic [CNT_W-1:0] rst_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr        <= PWR_SLEEP;
      rst_cnt    <= '0;
      ext_clk_o  <= 1'b0;
      clk_rate_o <= CLK_RATE_RST;
    end else begin
      if (rst_cnt != '0) rst_cnt <= rst_cnt - 1'b1;
      case (pwr)
        PWR_SLEEP: begin
          if (wake_i) begin
            pwr     <= PWR_ACTIVE;
            rst_cnt <= CNT_W'(RST_CYCLES);
          end else if (cmd_i) begin
            if (code_i == HC_EXT_CLK)       ext_clk_o  <= 1'b1;
            else if (code_i == HC_CLK_RATE) clk_rate_o <= param_i;
          end
        end
        default: begin
          if (cmd_i && code_i == HC_CORE_RST) rst_cnt <= CNT_W'(RST_CYCLES);
        end
      endcase
    end
  end

  assign active_o = (pwr == PWR_ACTIVE);
  assign busy_o   = (rst_cnt != '0);
endmodule

// File: rtl/spi_reg_store.sv
module spi_reg_store import spi_regmap_pkg::*; #(
  parameter int                DEPTH = 16,
  parameter logic [ADDR_W-1:0] BASE  = 22'h000010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              busy_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] off;
  logic              hit;

  assign off = addr_i - BASE;
  assign hit = (addr_i >= BASE) && (off < ADDR_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i && active_i && hit) begin
      mem[off[IDX_W-1:0]] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (active_i) begin
      if (addr_i == ADDR_ID)          rdata_o = ID_CODE;
      else if (addr_i == ADDR_CPURST) rdata_o = {7'd0, busy_i};
      else if (hit)                   rdata_o = mem[off[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/spi_regmap_slave.sv
module spi_regmap_slave import spi_regmap_pkg::*; #(
  parameter int                DEPTH        = 16,
  parameter logic [ADDR_W-1:0] BASE         = 22'h000010,
  parameter int                RST_CYCLES   = 2000,
  parameter logic [7:0]        CLK_RATE_RST = 8'd60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       active_o,
  output logic       ext_clk_o,
  output logic [7:0] clk_rate_o
);
  logic [2:0] pins_s;
  logic       cs_s, sck_s, mosi_s, cs_q;
  logic       sel, start, frame_end;

  spi_pin_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .async_i({cs_ni, sck_i, mosi_i}),
    .sync_o (pins_s)
  );
  assign {cs_s, sck_s, mosi_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b1;
    else         cs_q <= cs_s;
  end
  assign sel       = ~cs_s;
  assign start     = cs_q & ~cs_s;
  assign frame_end = ~cs_q & cs_s;

  logic       load_slot, ld, byte_done;
  logic [7:0] rx_byte, rd_data;

  spi_byte_shifter u_shift (
    .clk_i, .rst_ni,
    .start_i    (start),
    .sel_i      (sel),
    .sck_i      (sck_s),
    .mosi_i     (mosi_s),
    .load_i     (ld),
    .load_byte_i(rd_data),
    .load_slot_o(load_slot),
    .byte_done_o(byte_done),
    .rx_byte_o  (rx_byte),
    .miso_o     (miso_o)
  );

  // byte_cnt counts full bytes of the frame, saturating at 4 (past the dummy byte)
  logic [2:0]        byte_cnt;
  xfer_kind_e        kind;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        hc_code, hc_param;
  logic              hc_zero, wr_en;

  assign wr_en = byte_done && (byte_cnt >= 3'd3) && (kind == KIND_WR);
  assign ld    = load_slot && (kind == KIND_RD) && (byte_cnt == 3'd4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_cnt <= '0;
      kind     <= KIND_XX;
      addr     <= '0;
      hc_code  <= '0;
      hc_param <= '0;
      hc_zero  <= 1'b0;
    end else if (start) begin
      byte_cnt <= '0;
    end else if (byte_done) begin
      case (byte_cnt)
        3'd0: begin
          kind              <= xfer_kind_e'(rx_byte[7:6]);
          addr[ADDR_W-1:16] <= rx_byte[5:0];
          hc_code           <= rx_byte;
        end
        3'd1: begin
          addr[15:8] <= rx_byte;
          hc_param   <= rx_byte;
        end
        3'd2: begin
          addr[7:0] <= rx_byte;
          hc_zero   <= (rx_byte == 8'h00);
        end
        default: if (wr_en) addr <= addr + 1'b1;
      endcase
      if (byte_cnt != 3'd4) byte_cnt <= byte_cnt + 3'd1;
    end else if (ld) begin
      addr <= addr + 1'b1;
    end
  end

  logic cmd_frame, wake, host_cmd, cpu_busy;
  assign cmd_frame = frame_end && (byte_cnt == 3'd3);
  assign wake      = cmd_frame && (kind == KIND_RD) && (addr == '0);
  assign host_cmd  = cmd_frame && (kind == KIND_HC) && hc_zero;

  spi_host_ctrl #(.RST_CYCLES(RST_CYCLES), .CLK_RATE_RST(CLK_RATE_RST)) u_host (
    .clk_i, .rst_ni,
    .wake_i    (wake),
    .cmd_i     (host_cmd),
    .code_i    (hc_code),
    .param_i   (hc_param),
    .active_o  (active_o),
    .ext_clk_o (ext_clk_o),
    .clk_rate_o(clk_rate_o),
    .busy_o    (cpu_busy)
  );

  spi_reg_store #(.DEPTH(DEPTH), .BASE(BASE)) u_store (
    .clk_i, .rst_ni,
    .active_i(active_o),
    .busy_i  (cpu_busy),
    .we_i    (wr_en),
    .addr_i  (addr),
    .wdata_i (rx_byte),
    .rdata_o (rd_data)
  );
endmodule

// File: rtl/spi_regmap_checker.sv
module spi_regmap_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       active_o,
  input logic       ext_clk_o,
  input logic [7:0] clk_rate_o,
  input logic       cpu_busy,
  input logic [7:0] rd_data,
  input logic [2:0] byte_cnt
);
  assert_byte_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cnt <= 3'd4);

  assert_asleep_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> rd_data == 8'h00);

  assert_active_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |=> active_o);

  assert_clk_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |=> ($stable(ext_clk_o) && $stable(clk_rate_o)));

  assert_ext_clk_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_clk_o |=> ext_clk_o);

  assert_busy_on_wake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> cpu_busy);

  assert_busy_needs_active_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_busy |-> active_o);
endmodule

bind spi_regmap_slave spi_regmap_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .active_o   (active_o),
  .ext_clk_o  (ext_clk_o),
  .clk_rate_o (clk_rate_o),
  .cpu_busy   (cpu_busy),
  .rd_data    (rd_data),
  .byte_cnt   (byte_cnt)
);

// File: tb/spi_regmap_slave_tb.sv
module spi_regmap_slave_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          HALF       = 8;
  localparam int          DEPTH      = 16;
  localparam logic [21:0] BASE       = 22'h000010;
  localparam int          RST_CYC    = 2000;
  localparam logic [7:0]  RATE_RST   = 8'd60;

  logic       clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       miso, active, ext_clk;
  logic [7:0] clk_rate;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regmap_slave #(.DEPTH(DEPTH), .BASE(BASE), .RST_CYCLES(RST_CYC), .CLK_RATE_RST(RATE_RST)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .active_o(active), .ext_clk_o(ext_clk), .clk_rate_o(clk_rate)
  );

  typedef struct {logic [7:0] val; string req;} exp_t;
  exp_t       exp_q[$];
  int         n_chk = 0, n_fail = 0;
  logic [7:0] mon_byte;
  event       mon_ev;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: compares every byte seen on MISO against the scoreboard queue
  initial forever begin
    @(mon_ev);
    if (exp_q.size() == 0) begin
      n_chk++; n_fail++;
      $display("FAIL R3 act=%0h exp=none", mon_byte);
    end else begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.req, {24'd0, mon_byte}, {24'd0, e.val});
    end
  end

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      rx[i] = miso;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [1:0] k, input logic [21:0] a);
    logic [7:0] r;
    xb({k, a[21:16]}, r);
    xb(a[15:8], r);
    xb(a[7:0], r);
  endtask

  // driver: queues dummy + data expectations, then clocks the read
  task automatic rd_chk(input logic [21:0] a, input int n, input logic [31:0] ev, input string req);
    logic [7:0] r;
    exp_q.push_back('{val: 8'h00, req: "R3"});
    for (int i = 0; i < n; i++) exp_q.push_back('{val: ev[8*i +: 8], req: req});
    cs_begin();
    send_hdr(2'b00, a);
    xb(8'h00, r); mon_byte = r; ->mon_ev;
    for (int i = 0; i < n; i++) begin
      xb(8'h00, r); mon_byte = r; ->mon_ev;
    end
    cs_end();
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] d, input int n);
    logic [7:0] r;
    cs_begin();
    send_hdr(2'b10, a);
    for (int i = 0; i < n; i++) xb(d[8*i +: 8], r);
    cs_end();
  endtask

  task automatic hcmd(input logic [7:0] c, input logic [7:0] p, input logic [7:0] z);
    logic [7:0] r;
    cs_begin();
    xb(c, r); xb(p, r); xb(z, r);
    cs_end();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R11 reset state
    check("R11", {31'd0, miso}, 0);
    check("R11", {31'd0, active}, 0);
    check("R11", {31'd0, ext_clk}, 0);
    check("R11", {24'd0, clk_rate}, {24'd0, RATE_RST});

    // R6 asleep: reads zero, writes dropped
    rd_chk(22'h0, 1, 32'h00, "R6");
    wr(BASE, 32'hA5, 1);

    // R9 clock commands while asleep
    hcmd(8'h44, 8'h00, 8'h00);
    check("R9", {31'd0, ext_clk}, 1);
    hcmd(8'h61, 8'h48, 8'h00);
    check("R9", {24'd0, clk_rate}, 32'h48);
    // R8 nonzero third byte ignored
    hcmd(8'h61, 8'h22, 8'h05);
    check("R8", {24'd0, clk_rate}, 32'h48);
    // R8 four-byte host frame ignored
    cs_begin(); xb(8'h61, r); xb(8'h33, r); xb(8'h00, r); xb(8'h00, r); cs_end();
    check("R8", {24'd0, clk_rate}, 32'h48);
    // R7 a 00 00 00 frame cut short must not wake
    cs_begin(); xb(8'h00, r); xb(8'h00, r); cs_end();
    check("R7", {31'd0, active}, 0);

    // R7 wake
    hcmd(8'h00, 8'h00, 8'h00);
    check("R7", {31'd0, active}, 1);
    rd_chk(22'h1, 1, 32'h01, "R10");
    rd_chk(22'h0, 1, 32'h7C, "R5");
    rd_chk(BASE, 1, 32'h00, "R6");

    // R9 locked once active
    hcmd(8'h61, 8'h10, 8'h00);
    check("R9", {24'd0, clk_rate}, 32'h48);
    hcmd(8'h00, 8'h00, 8'h00);
    check("R7", {31'd0, active}, 1);

    // R10 reset interval ends
    repeat (RST_CYC + 20) @(negedge clk);
    rd_chk(22'h1, 1, 32'h00, "R10");

    // R4 little-endian 32-bit write, R3 incrementing read
    wr(BASE, 32'h11223344, 4);
    rd_chk(BASE, 4, 32'h11223344, "R4");
    rd_chk(BASE + 22'd2, 1, 32'h22, "R3");
    rd_chk(22'h0, 2, 32'h007C, "R5");

    // R5 range edges and read-only registers
    wr(BASE + 22'(DEPTH - 1), 32'hBEEF, 2);
    rd_chk(BASE + 22'(DEPTH - 1), 2, 32'h00EF, "R5");
    wr(22'h5, 32'h77, 1);
    rd_chk(22'h5, 1, 32'h00, "R5");
    wr(22'h0, 32'h12, 1);
    rd_chk(22'h0, 1, 32'h7C, "R5");

    // R1 partial trailing byte discarded
    cs_begin(); send_hdr(2'b10, BASE + 22'd4); xb(8'h5A, r); spi_bits(8'hC3, 5, r); cs_end();
    rd_chk(BASE + 22'd4, 2, 32'h005A, "R1");

    // R2 kinds 11 and 01 do not write
    cs_begin(); send_hdr(2'b11, BASE + 22'd8); xb(8'h66, r); cs_end();
    rd_chk(BASE + 22'd8, 1, 32'h00, "R2");
    cs_begin(); send_hdr(2'b01, BASE + 22'd9); xb(8'h66, r); cs_end();
    rd_chk(BASE + 22'd9, 1, 32'h00, "R2");
    check("R3", {31'd0, miso}, 0);

    // R10 core reset while active
    hcmd(8'h68, 8'h00, 8'h00);
    rd_chk(22'h1, 1, 32'h01, "R10");
    repeat (RST_CYC + 20) @(negedge clk);
    rd_chk(22'h1, 1, 32'h00, "R10");

    repeat (10) @(negedge clk);
    check("R3", exp_q.size(), 0);
    finish_run();
  end
endmodule